// File: doc/BRIEF.md
# Nested Hardware Loop Counter Unit

This block keeps the iteration state of two nested zero-overhead loops for a processor core. Each loop owns a count register and a bottom-address register. Every time the core retires an instruction, the block compares the instruction's address with both bottom addresses. It decrements the matching counts, and the inner loop always takes priority over the outer one. When a decrement leaves iterations still to run, the block raises a one-cycle taken pulse that tells the fetch side to branch back to the loop top. The fetch side computes the branch target itself.

Loop 1 is the inner loop and is evaluated first. If its count is decremented and is still nonzero afterwards, the outer loop (loop 0) is left alone in that cycle. If the inner loop does not match, or its count falls to zero, the outer loop is evaluated in the same cycle. The retire strobe counts whether or not the instruction redirected program flow.

Bit 0 of each bottom register acts as a guard. Instruction addresses are even, so a bottom with bit 0 set can never match. When the core enters supervisor state, the block sets the guard bit on both bottoms. This stops loops armed in user state from firing inside privileged code. When the core drops back to user state with no event pending, the block clears the guard bits again. Software can load any count or bottom register through a write port.

Top module: `zloop_track`

## Requirements
- R1: After reset, every count and every bottom register reads zero, `loop_taken` is low and `taken_idx` is zero.
- R2: A loop is a candidate on a cycle with `retire_vld` high when its count is nonzero and `retire_pc` equals its bottom register on all bits. A candidate that is evaluated has its count reduced by one at the next clock edge.
- R3: Loop 1 (the inner loop) is evaluated before loop 0. If loop 1 is decremented and its new count is nonzero, loop 0 is not examined in that cycle and keeps its count.
- R4: If loop 1 is not a candidate, or its decrement brings it to zero, loop 0 is evaluated in the same cycle. Both counts can therefore fall in one cycle.
- R5: A count of zero is never decremented and never wraps.
- R6: `loop_taken` is high for exactly the one cycle after the edge at which a decrement left a nonzero count. `taken_idx` gives that loop's index (1 = inner, 0 = outer).
- R7: A count write (`cnt_we[i]` with `cnt_wdata`) loads the value at the next edge and overrides a decrement of the same register in that cycle. The loop evaluation and `loop_taken` use the count values from before the write.
- R8: A `to_super` pulse sets bit 0 of every bottom register and leaves all other bits unchanged. The address compare in that same cycle still uses the old bottom values.
- R9: A `to_user` pulse clears bit 0 of every bottom register and leaves all other bits unchanged.
- R10: A bottom write (`bot_we[i]` with `bot_wdata`) overrides a guard update of that register in the same cycle. If `to_super` and `to_user` arrive together, `to_super` wins.
- R11: With `retire_vld` low and no count write, every count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_vld | input | 1 | An instruction retired this cycle |
| retire_pc | input | ADDR_W | Address of the retired instruction |
| to_super | input | 1 | Pulse: core moves from user to supervisor state |
| to_user | input | 1 | Pulse: core returns to user state, no event pending |
| cnt_we | input | NUM_LOOPS | Per-loop count write enable |
| cnt_wdata | input | CNT_W | Count write data |
| bot_we | input | NUM_LOOPS | Per-loop bottom write enable |
| bot_wdata | input | ADDR_W | Bottom write data |
| cnt_q | output | NUM_LOOPS*CNT_W | Counts, loop i at bits [i*CNT_W +: CNT_W] |
| bot_q | output | NUM_LOOPS*ADDR_W | Bottoms, loop i at bits [i*ADDR_W +: ADDR_W] |
| loop_taken | output | 1 | One-cycle pulse: branch back to a loop top |
| taken_idx | output | IDX_W | Loop that caused `loop_taken` |

## Verification
Two collisions matter here. The first is a retirement that decrements a count in the same cycle that software writes that count. The second is a retirement that matches a bottom address in the same cycle that a privilege pulse flips that bottom's guard bit. The bench provokes each one by driving the retire strobe and the write or pulse at the same falling edge. It then judges the result one edge later. The written count must win. The taken pulse and the outer loop's fate must follow the pre-write inner count. The compare must use the unguarded bottom, and the next retirement at that address must miss.

// File: rtl/zloop_pkg.sv
package zloop_pkg;

  // Guard-bit action applied to every bottom register in one cycle
  typedef enum logic [1:0] {
    GRD_KEEP = 2'd0,
    GRD_SET  = 2'd1,
    GRD_CLR  = 2'd2
  } grd_op_e;

  // Entering supervisor state dominates a simultaneous return to user
  function automatic grd_op_e grd_pick(input logic enter_sv, input logic leave_sv);
    if (enter_sv) return GRD_SET;
    if (leave_sv) return GRD_CLR;
    return GRD_KEEP;
  endfunction

endpackage

// File: rtl/zloop_match.sv
module zloop_match #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              retire_vld,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] bot,
  input  logic [CNT_W-1:0]  cnt,
  output logic              hit,
  output logic [CNT_W-1:0]  cnt_nxt,
  output logic              remain
);

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  function automatic logic is_live(input logic [CNT_W-1:0] c);
    return |c;
  endfunction

  // Full-width compare: a guarded (odd) bottom cannot match an even pc
  assign hit     = retire_vld && is_live(cnt) && (pc == bot);
  assign cnt_nxt = cnt_step(cnt);
  assign remain  = is_live(cnt_nxt);

endmodule

// File: rtl/zloop_chain.sv
module zloop_chain #(
  parameter int NUM_LOOPS = 2,
  parameter int IDX_W     = 1
) (
  input  logic [NUM_LOOPS-1:0] hit,
  input  logic [NUM_LOOPS-1:0] remain,
  output logic [NUM_LOOPS-1:0] fire,
  output logic                 taken_any,
  output logic [IDX_W-1:0]     idx
);

  // reach[i+1] says loop i is still examined; the highest index goes first
  logic [NUM_LOOPS:0] reach;
  assign reach[NUM_LOOPS] = 1'b1;

  for (genvar i = NUM_LOOPS - 1; i >= 0; i--) begin : g_stage
    assign fire[i]  = reach[i+1] & hit[i];
    assign reach[i] = reach[i+1] & ~(fire[i] & remain[i]);
  end

  logic [NUM_LOOPS-1:0] stay;
  assign stay      = fire & remain;
  assign taken_any = |stay;

  // At most one stage can stop the chain, so a plain scan suffices
  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_LOOPS; i++) begin
      if (stay[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/zloop_slot.sv
module zloop_slot
  import zloop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              dec,
  input  logic [CNT_W-1:0]  cnt_nxt,
  input  logic              bot_we,
  input  logic [ADDR_W-1:0] bot_wdata,
  input  grd_op_e           grd,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [ADDR_W-1:0] bot_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_wdata;
    end else if (dec) begin
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bot_q <= '0;
    end else if (bot_we) begin
      bot_q <= bot_wdata;
    end else begin
      unique case (grd)
        GRD_SET: bot_q[0] <= 1'b1;
        GRD_CLR: bot_q[0] <= 1'b0;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/zloop_track.sv
module zloop_track
  import zloop_pkg::*;
#(
  parameter int NUM_LOOPS = 2,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 32,
  localparam int IDX_W    = (NUM_LOOPS > 1) ? $clog2(NUM_LOOPS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        retire_vld,
  input  logic [ADDR_W-1:0]           retire_pc,
  input  logic                        to_super,
  input  logic                        to_user,
  input  logic [NUM_LOOPS-1:0]        cnt_we,
  input  logic [CNT_W-1:0]            cnt_wdata,
  input  logic [NUM_LOOPS-1:0]        bot_we,
  input  logic [ADDR_W-1:0]           bot_wdata,
  output logic [NUM_LOOPS*CNT_W-1:0]  cnt_q,
  output logic [NUM_LOOPS*ADDR_W-1:0] bot_q,
  output logic                        loop_taken,
  output logic [IDX_W-1:0]            taken_idx
);

  // Named internal events, visible to the bound checker
  logic [NUM_LOOPS-1:0] hit;
  logic [NUM_LOOPS-1:0] remain;
  logic [NUM_LOOPS-1:0] fire;
  logic                 taken_any;
  logic [IDX_W-1:0]     taken_sel;
  grd_op_e              grd;

  logic [CNT_W-1:0]  cnt_arr [NUM_LOOPS];
  logic [CNT_W-1:0]  nxt_arr [NUM_LOOPS];
  logic [ADDR_W-1:0] bot_arr [NUM_LOOPS];

  assign grd = grd_pick(to_super, to_user);

  for (genvar i = 0; i < NUM_LOOPS; i++) begin : g_loop
    zloop_match #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_match (
      .retire_vld (retire_vld),
      .pc         (retire_pc),
      .bot        (bot_arr[i]),
      .cnt        (cnt_arr[i]),
      .hit        (hit[i]),
      .cnt_nxt    (nxt_arr[i]),
      .remain     (remain[i])
    );

    zloop_slot #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_we    (cnt_we[i]),
      .cnt_wdata (cnt_wdata),
      .dec       (fire[i]),
      .cnt_nxt   (nxt_arr[i]),
      .bot_we    (bot_we[i]),
      .bot_wdata (bot_wdata),
      .grd       (grd),
      .cnt_q     (cnt_arr[i]),
      .bot_q     (bot_arr[i])
    );

    assign cnt_q[i*CNT_W +: CNT_W]   = cnt_arr[i];
    assign bot_q[i*ADDR_W +: ADDR_W] = bot_arr[i];
  end

  zloop_chain #(.NUM_LOOPS(NUM_LOOPS), .IDX_W(IDX_W)) u_chain (
    .hit       (hit),
    .remain    (remain),
    .fire      (fire),
    .taken_any (taken_any),
    .idx       (taken_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loop_taken <= 1'b0;
      taken_idx  <= '0;
    end else begin
      loop_taken <= taken_any;
      taken_idx  <= taken_any ? taken_sel : '0;
    end
  end

endmodule

// File: rtl/zloop_track_chk.sv
module zloop_track_chk #(
  parameter int NUM_LOOPS = 2,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 32,
  parameter int IDX_W     = 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        retire_vld,
  input logic                        to_super,
  input logic                        to_user,
  input logic [NUM_LOOPS-1:0]        cnt_we,
  input logic [CNT_W-1:0]            cnt_wdata,
  input logic [NUM_LOOPS-1:0]        bot_we,
  input logic [ADDR_W-1:0]           bot_wdata,
  input logic [NUM_LOOPS*CNT_W-1:0]  cnt_q,
  input logic [NUM_LOOPS*ADDR_W-1:0] bot_q,
  input logic                        loop_taken,
  input logic [IDX_W-1:0]            taken_idx,
  input logic [NUM_LOOPS-1:0]        fire,
  input logic [NUM_LOOPS-1:0]        remain
);

  localparam int HI = NUM_LOOPS - 1;

  logic [CNT_W-1:0]  c_hi, c_lo;
  logic [ADDR_W-1:0] b_lo;
  logic [NUM_LOOPS-1:0] stay;
  assign c_hi = cnt_q[HI*CNT_W +: CNT_W];
  assign c_lo = cnt_q[0 +: CNT_W];
  assign b_lo = bot_q[0 +: ADDR_W];
  assign stay = fire & remain;

  p_dec_inner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && fire[HI] && !cnt_we[HI]) |=> (c_hi == $past(c_hi) - CNT_W'(1)));

  p_outer_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire[HI] && remain[HI] && !cnt_we[0]) |=> $stable(c_lo));

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_lo == '0 && !cnt_we[0]) |=> (c_lo == '0));

  p_taken_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loop_taken |-> ((($past(stay) >> taken_idx) & NUM_LOOPS'(1)) != '0));

  p_taken_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stay == '0) |=> !loop_taken);

  p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we[HI] |=> (c_hi == $past(cnt_wdata)));

  p_guard_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (to_super && !bot_we[0]) |=> b_lo[0]);

  p_guard_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (to_user && !to_super && !bot_we[0]) |=> !b_lo[0]);

  p_bot_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bot_we[0] |=> (b_lo == $past(bot_wdata)));

  p_bot_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bot_we == '0 && !to_super && !to_user) |=> $stable(bot_q));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_vld && cnt_we == '0) |=> $stable(cnt_q));

endmodule

bind zloop_track zloop_track_chk #(
  .NUM_LOOPS (NUM_LOOPS),
  .ADDR_W    (ADDR_W),
  .CNT_W     (CNT_W),
  .IDX_W     (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .retire_vld (retire_vld),
  .to_super   (to_super),
  .to_user    (to_user),
  .cnt_we     (cnt_we),
  .cnt_wdata  (cnt_wdata),
  .bot_we     (bot_we),
  .bot_wdata  (bot_wdata),
  .cnt_q      (cnt_q),
  .bot_q      (bot_q),
  .loop_taken (loop_taken),
  .taken_idx  (taken_idx),
  .fire       (fire),
  .remain     (remain)
);

// File: tb/sim_zloop_track.sv
module sim_zloop_track;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire_vld = 1'b0;
  logic [31:0] retire_pc = '0;
  logic        to_super = 1'b0;
  logic        to_user = 1'b0;
  logic [1:0]  cnt_we = '0;
  logic [31:0] cnt_wdata = '0;
  logic [1:0]  bot_we = '0;
  logic [31:0] bot_wdata = '0;
  logic [63:0] cnt_q;
  logic [63:0] bot_q;
  logic        loop_taken;
  logic [0:0]  taken_idx;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  zloop_track u0 (
    .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld), .retire_pc(retire_pc),
    .to_super(to_super), .to_user(to_user), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .bot_we(bot_we), .bot_wdata(bot_wdata), .cnt_q(cnt_q), .bot_q(bot_q),
    .loop_taken(loop_taken), .taken_idx(taken_idx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, release, sample
  task automatic step;
    @(negedge clk);
    retire_vld = 1'b0; to_super = 1'b0; to_user = 1'b0;
    cnt_we = '0; bot_we = '0;
  endtask

  task automatic load(input logic [31:0] c1, c0, b1, b0);
    cnt_we = 2'b10; cnt_wdata = c1; bot_we = 2'b10; bot_wdata = b1; step();
    cnt_we = 2'b01; cnt_wdata = c0; bot_we = 2'b01; bot_wdata = b0; step();
  endtask

  task automatic retire(input logic [31:0] pc);
    retire_vld = 1'b1; retire_pc = pc; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 counts", cnt_q[31:0] | cnt_q[63:32], 0);
    chk("R1 bottoms", bot_q[31:0] | bot_q[63:32], 0);
    chk("R1 taken", {31'd0, loop_taken}, 0);

    // Sweep: inner/outer counts 0..3, pc hitting none/inner/outer/both
    for (int c1 = 0; c1 < 4; c1++) begin
      for (int c0 = 0; c0 < 4; c0++) begin
        for (int m = 0; m < 4; m++) begin
          logic [31:0] b1, b0, pc, e1, e0;
          bit tk, ti, go;
          b1 = 32'h100;
          b0 = (m == 3) ? 32'h100 : 32'h200;
          pc = (m == 0) ? 32'h300 : (m == 2) ? 32'h200 : 32'h100;
          e1 = c1; e0 = c0; tk = 0; ti = 0; go = 1;
          if (pc == b1 && c1 != 0) begin
            e1 = c1 - 1;
            if (e1 != 0) begin tk = 1; ti = 1; go = 0; end
          end
          if (go && pc == b0 && c0 != 0) begin
            e0 = c0 - 1;
            if (e0 != 0) begin tk = 1; ti = 0; end
          end
          load(c1, c0, b1, b0);
          retire(pc);
          chk("R2/R3/R5 inner count", cnt_q[63:32], e1);
          chk("R2/R4/R5 outer count", cnt_q[31:0], e0);
          chk("R6 taken", {30'd0, loop_taken, tk ? taken_idx : 1'b0}, {30'd0, tk, ti});
          step();
          chk("R6 pulse ends", {31'd0, loop_taken}, 0);
        end
      end
    end

    // R11: idle cycles hold counts
    load(32'd6, 32'd2, 32'h40, 32'h80);
    step(); step();
    chk("R11 inner hold", cnt_q[63:32], 6);
    chk("R11 outer hold", cnt_q[31:0], 2);

    // R7: write to inner during its decrement; chain uses pre-write count
    load(32'd5, 32'd3, 32'h40, 32'h40);
    retire_vld = 1'b1; retire_pc = 32'h40; cnt_we = 2'b10; cnt_wdata = 32'd9; step();
    chk("R7 write wins", cnt_q[63:32], 9);
    chk("R7 outer untouched", cnt_q[31:0], 3);
    chk("R7 taken inner", {30'd0, loop_taken, taken_idx}, {30'd0, 1'b1, 1'b1});

    // R7: write to outer during its decrement
    load(32'd0, 32'd4, 32'h40, 32'h60);
    retire_vld = 1'b1; retire_pc = 32'h60; cnt_we = 2'b01; cnt_wdata = 32'd7; step();
    chk("R7 outer write wins", cnt_q[31:0], 7);
    chk("R7 taken outer", {30'd0, loop_taken, taken_idx}, {30'd0, 1'b1, 1'b0});

    // R8: guard set in same cycle as a match on the old bottom
    load(32'd4, 32'd0, 32'h100, 32'h201);
    retire_vld = 1'b1; retire_pc = 32'h100; to_super = 1'b1; step();
    chk("R8 old bottom matched", cnt_q[63:32], 3);
    chk("R8 inner guarded", bot_q[63:32], 32'h101);
    chk("R8 outer already set", bot_q[31:0], 32'h201);
    retire(32'h100);
    chk("R8 guarded bottom misses", cnt_q[63:32], 3);

    // R9: return to user clears guards
    to_user = 1'b1; step();
    chk("R9 inner cleared", bot_q[63:32], 32'h100);
    chk("R9 outer cleared", bot_q[31:0], 32'h200);
    retire(32'h100);
    chk("R9 matches again", cnt_q[63:32], 2);

    // R10: bottom write beats guard; to_super beats to_user
    bot_we = 2'b01; bot_wdata = 32'h300; to_super = 1'b1; step();
    chk("R10 write beats guard", bot_q[31:0], 32'h300);
    chk("R10 other bottom guarded", bot_q[63:32], 32'h101);
    to_user = 1'b1; step();
    to_super = 1'b1; to_user = 1'b1; step();
    chk("R10 super wins outer", bot_q[31:0], 32'h301);
    chk("R10 super wins inner", bot_q[63:32], 32'h101);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule